// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small processor core built around a single accumulator. Each 16-bit instruction word holds a 4-bit operation code in its top hex digit and a 12-bit word address below it. The core alternates a fetch phase and an execute phase. Every memory access passes through a memory address register (MAR) and a memory buffer register (MBR). All accesses use one synchronous word-wide memory port that returns read data one cycle after the read strobe.

Three operations are recognised: load the accumulator, add a memory word to it, and store it. Any other code halts the core until reset. The start address is a parameter, 0x300 by default. The current sequencer state is brought out on a port, so a bench or a debug probe can follow the machine cycle by cycle. The accumulator, the carry of the last add and a halt flag are also outputs.

Top module: `acc_core`

## Requirements
- R1: While reset is low and in the first cycle after it, state_o is 0, acc_o is 0, carry_o is 0, halted_o is 0 and neither strobe is high. The first fetch reads address RESET_PC (default 0x300).
- R2: Each fetch reads the instruction at the program counter with a one-cycle mem_re pulse and then advances the counter by one. Successive fetch addresses are consecutive.
- R3: Code 0x1 in bits 15:12 loads the accumulator with the word at the address in bits 11:0. Carry is left unchanged.
- R4: Code 0x5 in bits 15:12 adds the word at the address in bits 11:0 to the accumulator, modulo 2^16.
- R5: carry_o takes bit 16 of the 17-bit sum on every add and does not change on any other cycle.
- R6: Code 0x2 in bits 15:12 writes the accumulator to the address in bits 11:0 with a mem_we pulse exactly one cycle long.
- R7: Read data is taken one cycle after the mem_re cycle. mem_re and mem_we are never high together.
- R8: Any other code sets halted_o. The flag stays set, and both strobes stay low, until reset.
- R9: state_o encodings are: 0 fetch address, 1 fetch read, 2 fetch capture, 3 instruction load, 4 operand address, 5 operand access, 6 operand capture, 7 accumulate, 8 halted. Load and add take 8 cycles. Store takes 6 cycles. An unknown code reaches state 8 five cycles after its fetch begins.
- R10: The program counter wraps from 0xFFF to 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address, driven from the MAR |
| mem_wdata | output | 16 | Write data, driven from the MBR |
| mem_re | output | 1 | Read strobe; data is returned in the following cycle |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 16 | Registered read data from memory |
| acc_o | output | 16 | Accumulator |
| carry_o | output | 1 | Carry out of the last add |
| halted_o | output | 1 | Set by an unknown operation code |
| state_o | output | 4 | Sequencer state code |

## Verification
The assertions watch the following properties on every cycle:
- the two strobes never overlap;
- the halt flag is sticky and the bus stays quiet while halted;
- the program counter steps by one after each fetch read;
- a load copies the buffered word, and carry holds outside an add;
- the written word equals the accumulator.

Only the bench's programs show the following:
- the arithmetic results, including carry and wraparound, stored back to memory;
- the exact cycle counts of each operation;
- that several different unknown codes all halt the core;
- that the program counter wraps past the top of the address space.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;

  typedef enum logic [3:0] {
    S_FADDR = 4'd0, S_FREAD = 4'd1, S_FCAP = 4'd2, S_IRLD = 4'd3,
    S_OADDR = 4'd4, S_OACC  = 4'd5, S_OCAP = 4'd6, S_ACCUM = 4'd7,
    S_HALT  = 4'd8
  } seq_state_t;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic pc_inc;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic ir_from_mbr;
    logic acc_load;
    logic acc_add;
  } ctrl_t;

  function automatic logic opc_known(input logic [OPC_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_ADD);
  endfunction
endpackage

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl,
  output logic             mem_re,
  output logic             mem_we,
  output logic             halted,
  output logic [3:0]       state_code
);
  seq_state_t state, state_nx;

  logic is_store;
  assign is_store = (opcode == OPC_STORE);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_FADDR;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    ctrl     = '0;
    mem_re   = 1'b0;
    mem_we   = 1'b0;
    unique case (state)
      S_FADDR: begin ctrl.mar_from_pc = 1'b1; state_nx = S_FREAD; end
      S_FREAD: begin mem_re = 1'b1; ctrl.pc_inc = 1'b1; state_nx = S_FCAP; end
      S_FCAP:  begin ctrl.mbr_from_mem = 1'b1; state_nx = S_IRLD; end
      S_IRLD:  begin ctrl.ir_from_mbr = 1'b1; state_nx = S_OADDR; end
      S_OADDR: begin
        if (opc_known(opcode)) begin
          ctrl.mar_from_ir  = 1'b1;
          ctrl.mbr_from_acc = 1'b1;
          state_nx = S_OACC;
        end else begin
          state_nx = S_HALT;
        end
      end
      S_OACC: begin
        if (is_store) begin mem_we = 1'b1; state_nx = S_FADDR; end
        else          begin mem_re = 1'b1; state_nx = S_OCAP;  end
      end
      S_OCAP:  begin ctrl.mbr_from_mem = 1'b1; state_nx = S_ACCUM; end
      S_ACCUM: begin
        ctrl.acc_load = (opcode == OPC_LOAD);
        ctrl.acc_add  = (opcode == OPC_ADD);
        state_nx = S_FADDR;
      end
      S_HALT:  state_nx = S_HALT;
      default: state_nx = S_HALT;
    endcase
  end

  assign halted     = (state == S_HALT);
  assign state_code = state;

  // R7
  re_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));
  // R6
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_we,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] acc,
  output logic              carry
);
  localparam int SUM_W = DATA_W + 1;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [SUM_W-1:0]  sum;

  function automatic logic [SUM_W-1:0] add_wide(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum    = add_wide(acc, mbr);
  assign opcode = ir[DATA_W-1 -: OPC_W];

  // named events for the checks below
  logic fetch_read, exec_load, exec_add;
  assign fetch_read = ctrl.pc_inc;
  assign exec_load  = ctrl.acc_load;
  assign exec_add   = ctrl.acc_add;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= RESET_PC;
      mar   <= '0;
      mbr   <= '0;
      ir    <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else begin
      if (ctrl.pc_inc)            pc  <= pc + 1'b1;
      if (ctrl.mar_from_pc)       mar <= pc;
      else if (ctrl.mar_from_ir)  mar <= ir[ADDR_W-1:0];
      if (ctrl.mbr_from_mem)      mbr <= mem_rdata;
      else if (ctrl.mbr_from_acc) mbr <= acc;
      if (ctrl.ir_from_mbr)       ir  <= mbr;
      if (exec_load)              acc <= mbr;
      if (exec_add) begin
        acc   <= sum[DATA_W-1:0];
        carry <= sum[DATA_W];
      end
    end
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_read |=> pc == $past(pc) + 1'b1);
  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_load |=> acc == $past(mbr));
  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_add |=> $stable(carry));
  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mbr == acc);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              halted_o,
  output logic [3:0]        state_o
);
  ctrl_t            ctrl;
  logic [OPC_W-1:0] opcode;

  acc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .ctrl       (ctrl),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .halted     (halted_o),
    .state_code (state_o)
  );

  acc_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mar       (mem_addr),
    .mbr       (mem_wdata),
    .opcode    (opcode),
    .acc       (acc_o),
    .carry     (carry_o)
  );
endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, acc_o;
  logic        mem_re, mem_we, carry_o, halted_o;
  logic [3:0]  state_o;

  always #5 clk = ~clk;

  acc_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_rdata(mem_rdata), .acc_o(acc_o),
    .carry_o(carry_o), .halted_o(halted_o), .state_o(state_o)
  );

  // bench memory: one-cycle registered read
  logic [15:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int tests = 0, fails = 0, gcyc = 0, cyc = 0;
  int seq_err, we_cnt, we_cyc, halt_cyc, halt_bus, last_fetch, have_prev;

  always @(posedge clk) begin
    gcyc <= gcyc + 1;
    cyc  <= rst_n ? cyc + 1 : 0;
    if (gcyc >= 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected < 190000", gcyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  // bus monitor, state code 1 = fetch read (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re && state_o == 4'd1) begin
        if (have_prev != 0 && mem_addr != 12'(last_fetch + 1)) seq_err = seq_err + 1;
        last_fetch = int'(mem_addr);
        have_prev  = 1;
      end
      if (mem_we) begin we_cnt = we_cnt + 1; we_cyc = cyc; end
      if (halted_o && halt_cyc < 0) halt_cyc = cyc;
      if (halted_o && (mem_re || mem_we)) halt_bus = halt_bus + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic start_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    seq_err = 0; we_cnt = 0; we_cyc = -1; halt_cyc = -1; halt_bus = 0;
    last_fetch = -1; have_prev = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    for (int n = 0; n < 60000 && !halted_o; n++) @(negedge clk);
  endtask

  // a, b, terminating word with an unknown code
  localparam logic [47:0] VEC [6] = '{
    {16'h1234, 16'h0001, 16'h0000},
    {16'hFFFF, 16'h0001, 16'h3000},
    {16'h8000, 16'h8000, 16'hF123},
    {16'h7FFF, 16'h7FFF, 16'h4ABC},
    {16'h0000, 16'h0000, 16'h6000},
    {16'hABCD, 16'h5433, 16'hE000}
  };

  initial begin
    // R1 reset state
    start_reset();
    check("R1 state in reset", int'(state_o), 0);
    check("R1 acc in reset", int'(acc_o), 0);
    check("R1 carry in reset", int'(carry_o), 0);
    check("R1 halt in reset", int'(halted_o), 0);
    check("R1 strobes in reset", int'({mem_re, mem_we}), 0);
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941; mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'h0001; mem[12'h941] = 16'h0002;
    release_reset();
    check("R1 first cycle state", int'(state_o), 0);
    check("R1 first cycle strobes", int'({mem_re, mem_we}), 0);
    @(negedge clk);
    check("R1 first fetch strobe", int'(mem_re), 1);
    check("R1 first fetch addr", int'(mem_addr), 12'h300);
    run_to_halt();
    repeat (20) @(negedge clk);
    check("R9 store write cycle", we_cyc, 21);
    check("R9 halt cycle", halt_cyc, 27);
    check("R6 one write pulse", we_cnt, 1);
    check("R6 stored sum", int'(mem[12'h941]), 3);
    check("R8 bus quiet when halted", halt_bus, 0);
    check("R8 halt held", int'(halted_o), 1);
    check("R9 halt code", int'(state_o), 8);
    check("R2 sequential fetch", seq_err, 0);
    check("R2 last fetch addr", last_fetch, 12'h303);

    // table: load a, add b, store, unknown code (R3 R4 R5 R6 R8)
    for (int v = 0; v < 6; v++) begin
      logic [16:0] s;
      start_reset();
      mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
      mem[12'h302] = 16'h2941; mem[12'h303] = VEC[v][15:0];
      mem[12'h940] = VEC[v][47:32]; mem[12'h941] = VEC[v][31:16];
      s = {1'b0, VEC[v][47:32]} + {1'b0, VEC[v][31:16]};
      release_reset();
      run_to_halt();
      repeat (4) @(negedge clk);
      check("R4 acc sum", int'(acc_o), int'(s[15:0]));
      check("R5 carry", int'(carry_o), int'(s[16]));
      check("R6 stored word", int'(mem[12'h941]), int'(s[15:0]));
      check("R8 halted on unknown code", int'(halted_o), 1);
      check("R8 no bus while halted", halt_bus, 0);
    end

    // R3 load only, carry untouched
    start_reset();
    mem[12'h300] = 16'h1A05; mem[12'h301] = 16'h0000; mem[12'hA05] = 16'hBEEF;
    release_reset();
    run_to_halt();
    check("R3 load value", int'(acc_o), 16'hBEEF);
    check("R3 load keeps carry", int'(carry_o), 0);
    check("R7 no write on load", we_cnt, 0);

    // R5 carry held across a later load
    start_reset();
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h1942;
    mem[12'h303] = 16'h2943; mem[12'h304] = 16'h7000;
    mem[12'h940] = 16'hFFFF; mem[12'h941] = 16'h0001; mem[12'h942] = 16'h1234;
    release_reset();
    run_to_halt();
    check("R5 carry kept after load", int'(carry_o), 1);
    check("R3 acc after second load", int'(acc_o), 16'h1234);
    check("R6 store after load", int'(mem[12'h943]), 16'h1234);

    // R10 counter wraps: loads through the top of memory, halt at 0x000
    start_reset();
    for (int a = 12'h300; a < 4096; a++) mem[a] = 16'h1000;
    mem[0] = 16'h0000;
    release_reset();
    run_to_halt();
    check("R10 wrapped fetch addr", last_fetch, 0);
    check("R10 sequential through wrap", seq_err, 0);
    check("R10 halted after wrap", int'(halted_o), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule